// File: doc/BRIEF.md
# Pipeline Data Hazard Unit

This block resolves data hazards in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. It has two independent halves. The bypass half looks at the instruction now in execute. It compares that instruction's two source register numbers with the destination numbers held in the execute/memory and memory/writeback pipeline registers. From that comparison it drives one select for each ALU operand multiplexer, which picks the register file value or one of the two in-flight results.

The load-use half works in decode. A load that is still in execute cannot supply its data in time to an instruction that needs it in the very next cycle. When the instruction in decode needs the load's destination, the block raises a stall. The stall holds the program counter and the fetch/decode register for one cycle and turns the decode/execute control word into a bubble. The decode opcode sets which source registers count. An opcode that does not read the loaded register never causes a stall, even when the register numbers happen to match.

The block is meant to sit beside the pipeline registers. Its selects steer the ALU operand multiplexers, and its stall outputs gate the enables of the PC and fetch/decode registers. It also gates the control clear of the decode/execute register.

Top module: `hazard_unit`

## Requirements
- R1: An operand select is 2'b10 when the execute/memory stage has write enable set, a nonzero destination, and a destination equal to that operand's source register.
- R2: An operand select is 2'b01 when R1 does not apply and the memory/writeback stage has write enable set, a nonzero destination, and a destination equal to that operand's source register.
- R3: When both stages match the same operand, the execute/memory result wins and the select is 2'b10.
- R4: A stage whose write enable is low, or whose destination is register 0, is never forwarded, and the select is 2'b00 (register file) when neither stage qualifies. The value 2'b11 never appears.
- R5: Operand A follows the execute-stage rs field and drives `fwd_a_o`. Operand B follows the execute-stage rt field and drives `fwd_b_o`. Each select is decided independently of the other, and of all decode-stage inputs.
- R6: With the execute-stage memory-read flag set and decode opcode 6'h00 (register-register), a stall is raised when the load destination (execute-stage rt) equals the decode rs or the decode rt. The comparison includes register 0.
- R7: With decode opcode 6'h2B (store), only a match on the decode rs stalls. A match on the decode rt alone (the store data) does not stall.
- R8: With decode opcode 6'h04 (branch on equal), a match on the decode rs or the decode rt stalls.
- R9: No stall occurs when the memory-read flag is low, or for any other opcode (for example 6'h23 load or 6'h08 immediate add), whatever the register numbers.
- R10: While stalled, `stall_o`=1, `pc_we_o`=0, `ifid_we_o`=0 and `bubble_o`=1. Otherwise `stall_o`=0, `pc_we_o`=1, `ifid_we_o`=1 and `bubble_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exmem_rd_i | input | REG_AW | Destination register in execute/memory register |
| exmem_wr_i | input | 1 | Register write enable in execute/memory register |
| memwb_rd_i | input | REG_AW | Destination register in memory/writeback register |
| memwb_wr_i | input | 1 | Register write enable in memory/writeback register |
| idex_rs_i | input | REG_AW | rs field of the instruction in execute |
| idex_rt_i | input | REG_AW | rt field of the instruction in execute (load destination) |
| idex_memrd_i | input | 1 | Instruction in execute reads memory (load) |
| ifid_rs_i | input | REG_AW | rs field of the instruction in decode |
| ifid_rt_i | input | REG_AW | rt field of the instruction in decode |
| ifid_opc_i | input | OPC_W | Opcode of the instruction in decode |
| fwd_a_o | output | 2 | ALU operand A source select |
| fwd_b_o | output | 2 | ALU operand B source select |
| stall_o | output | 1 | Load-use hazard detected |
| pc_we_o | output | 1 | PC write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| bubble_o | output | 1 | Clear decode/execute control bits |

## Verification
The hardest situations to reach are those where several comparisons agree at once. Both stages may match the same operand, one of them pointing at register 0 or with its write enable off. A store may match the load only on its data field. Uniform random register numbers almost never line up like this. So the random stimulus draws register numbers from a pool of four values that includes 0, and draws opcodes from a short list that mixes hazard-relevant and irrelevant ones. Directed vectors then pin down the priority tie, the register-0 cases and the store rt-only case exactly.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_LW    = 6'h23;
  localparam logic [OPC_W-1:0] OPC_SW    = 6'h2B;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_sel_unit.sv
module fwd_sel_unit
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              exmem_wr_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              memwb_wr_i,
  output logic [1:0]        sel_o
);
  logic exmem_hit, memwb_hit;

  assign exmem_hit = exmem_wr_i && (exmem_rd_i != '0) && (exmem_rd_i == src_i);
  assign memwb_hit = memwb_wr_i && (memwb_rd_i != '0) && (memwb_rd_i == src_i);

  // newest result has priority
  always_comb begin
    if (exmem_hit)      sel_o = SEL_EXMEM;
    else if (memwb_hit) sel_o = SEL_MEMWB;
    else                sel_o = SEL_RF;
  end

  always_comb begin
    assert_legal_sel_R4: assert (sel_o != 2'b11);
    if (sel_o == SEL_EXMEM)
      assert_exmem_valid_R1: assert (exmem_wr_i && exmem_rd_i != '0 && exmem_rd_i == src_i);
    if (sel_o == SEL_MEMWB)
      assert_memwb_valid_R2: assert (memwb_wr_i && memwb_rd_i != '0 && memwb_rd_i == src_i);
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              memrd_i,
  input  logic [REG_AW-1:0] ld_rd_i,
  input  logic [REG_AW-1:0] rs_i,
  input  logic [REG_AW-1:0] rt_i,
  input  logic [OPC_W-1:0]  opc_i,
  output logic              stall_o
);
  logic need_rs, need_rt;

  // store data (rt) is not a load-use source
  always_comb begin
    unique case (opc_i)
      OPC_RTYPE, OPC_BEQ: begin need_rs = 1'b1; need_rt = 1'b1; end
      OPC_SW:             begin need_rs = 1'b1; need_rt = 1'b0; end
      default:            begin need_rs = 1'b0; need_rt = 1'b0; end
    endcase
  end

  assign stall_o = memrd_i &&
                   ((need_rs && ld_rd_i == rs_i) || (need_rt && ld_rd_i == rt_i));

  always_comb begin
    if (stall_o) begin
      assert_stall_needs_load_R9: assert (memrd_i);
      assert_stall_opcode_R9: assert (opc_i == OPC_RTYPE || opc_i == OPC_SW || opc_i == OPC_BEQ);
    end
    if (stall_o && opc_i == OPC_SW)
      assert_store_rs_only_R7: assert (ld_rd_i == rs_i);
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              exmem_wr_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              memwb_wr_i,
  input  logic [REG_AW-1:0] idex_rs_i,
  input  logic [REG_AW-1:0] idex_rt_i,
  input  logic              idex_memrd_i,
  input  logic [REG_AW-1:0] ifid_rs_i,
  input  logic [REG_AW-1:0] ifid_rt_i,
  input  logic [OPC_W-1:0]  ifid_opc_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              stall_o,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              bubble_o
);
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][REG_AW-1:0] op_src;
  logic [N_OPS-1:0][1:0]        op_sel;
  logic                         lu_stall;

  assign op_src[0] = idex_rs_i;
  assign op_src[1] = idex_rt_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_fwd
    fwd_sel_unit #(.REG_AW(REG_AW)) i_fwd (
      .src_i      (op_src[g]),
      .exmem_rd_i (exmem_rd_i),
      .exmem_wr_i (exmem_wr_i),
      .memwb_rd_i (memwb_rd_i),
      .memwb_wr_i (memwb_wr_i),
      .sel_o      (op_sel[g])
    );
  end

  assign fwd_a_o = op_sel[0];
  assign fwd_b_o = op_sel[1];

  load_use_detect #(.REG_AW(REG_AW)) i_lu (
    .memrd_i (idex_memrd_i),
    .ld_rd_i (idex_rt_i),
    .rs_i    (ifid_rs_i),
    .rt_i    (ifid_rt_i),
    .opc_i   (ifid_opc_i),
    .stall_o (lu_stall)
  );

  assign stall_o   = lu_stall;
  assign pc_we_o   = ~lu_stall;
  assign ifid_we_o = ~lu_stall;
  assign bubble_o  = lu_stall;

  always_comb begin
    if (fwd_a_o == SEL_EXMEM && fwd_b_o == SEL_EXMEM)
      assert_both_ops_same_R5: assert (idex_rs_i == idex_rt_i);
    if (!idex_memrd_i)
      assert_no_hold_wo_load_R10: assert (pc_we_o && ifid_we_o && !bubble_o);
  end
endmodule

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] exmem_rd = '0, memwb_rd = '0, idex_rs = '0, idex_rt = '0;
  logic [AW-1:0] ifid_rs = '0, ifid_rt = '0;
  logic          exmem_wr = 1'b0, memwb_wr = 1'b0, idex_memrd = 1'b0;
  logic [5:0]    ifid_opc = 6'h08;
  logic [1:0]    fwd_a, fwd_b;
  logic          stall, pc_we, ifid_we, bubble;

  int n_chk = 0, n_err = 0;

  hazard_unit #(.REG_AW(AW)) i_hazard_unit (
    .exmem_rd_i(exmem_rd), .exmem_wr_i(exmem_wr),
    .memwb_rd_i(memwb_rd), .memwb_wr_i(memwb_wr),
    .idex_rs_i(idex_rs), .idex_rt_i(idex_rt), .idex_memrd_i(idex_memrd),
    .ifid_rs_i(ifid_rs), .ifid_rt_i(ifid_rt), .ifid_opc_i(ifid_opc),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall),
    .pc_we_o(pc_we), .ifid_we_o(ifid_we), .bubble_o(bubble)
  );

  function automatic logic [1:0] exp_sel(logic [AW-1:0] src);
    if (exmem_wr && exmem_rd != 0 && exmem_rd == src) return 2'b10;
    if (memwb_wr && memwb_rd != 0 && memwb_rd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    if (!idex_memrd) return 1'b0;
    case (ifid_opc)
      6'h00, 6'h04: return (idex_rt == ifid_rs) || (idex_rt == ifid_rt);
      6'h2B:        return idex_rt == ifid_rs;
      default:      return 1'b0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic check_all(string req);
    logic es;
    logic [3:0] ctl_a, ctl_e;
    @(negedge clk);
    es    = exp_stall();
    ctl_a = {stall, pc_we, ifid_we, bubble};
    ctl_e = {es, ~es, ~es, es};
    check(fwd_a == exp_sel(idex_rs), {req, " fwd_a"}, fwd_a, exp_sel(idex_rs));
    check(fwd_b == exp_sel(idex_rt), {req, " fwd_b"}, fwd_b, exp_sel(idex_rt));
    check(ctl_a == ctl_e, {req, " stall ctl R10"}, ctl_a, ctl_e);
  endtask

  task automatic set_fwd(logic [AW-1:0] er, logic ew, logic [AW-1:0] mr, logic mw,
                         logic [AW-1:0] rs, logic [AW-1:0] rt);
    @(posedge clk);
    exmem_rd = er; exmem_wr = ew; memwb_rd = mr; memwb_wr = mw;
    idex_rs = rs; idex_rt = rt;
  endtask

  task automatic set_lu(logic mrd, logic [5:0] opc, logic [AW-1:0] rs, logic [AW-1:0] rt);
    @(posedge clk);
    idex_memrd = mrd; ifid_opc = opc; ifid_rs = rs; ifid_rt = rt;
  endtask

  initial begin
    fork
      begin
        #(5ns * 150000);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    join_none

    // idle state
    @(negedge clk);
    check(fwd_a == 2'b00 && fwd_b == 2'b00, "R4 idle selects", {fwd_a, fwd_b}, 0);
    check(pc_we && ifid_we && !stall && !bubble, "R10 idle ctl", {stall, pc_we, ifid_we, bubble}, 4'b0110);

    // R1 EX/MEM forward on A
    set_fwd(5'd3, 1, 5'd0, 0, 5'd3, 5'd7); check_all("R1");
    check(fwd_a == 2'b10, "R1 direct", fwd_a, 2);
    // R2 MEM/WB forward on B
    set_fwd(5'd9, 1, 5'd7, 1, 5'd3, 5'd7); check_all("R2");
    check(fwd_b == 2'b01, "R2 direct", fwd_b, 1);
    // R3 both match, EX/MEM wins
    set_fwd(5'd5, 1, 5'd5, 1, 5'd5, 5'd5); check_all("R3");
    check(fwd_a == 2'b10 && fwd_b == 2'b10, "R3 priority", {fwd_a, fwd_b}, 4'b1010);
    // R4 register 0 and write-disabled EX/MEM fall through
    set_fwd(5'd0, 1, 5'd0, 1, 5'd0, 5'd0); check_all("R4");
    check(fwd_a == 2'b00, "R4 r0", fwd_a, 0);
    set_fwd(5'd6, 0, 5'd6, 1, 5'd6, 5'd1); check_all("R4");
    check(fwd_a == 2'b01, "R4 wr off falls to memwb", fwd_a, 1);
    // R5 independent operands
    set_fwd(5'd2, 1, 5'd4, 1, 5'd4, 5'd2); check_all("R5");
    check(fwd_a == 2'b01 && fwd_b == 2'b10, "R5 independent", {fwd_a, fwd_b}, 4'b0110);

    // R6 R-type on rt
    set_fwd(5'd8, 1, 5'd0, 0, 5'd1, 5'd8);
    set_lu(1, 6'h00, 5'd2, 5'd8); check_all("R6");
    check(stall, "R6 rtype rt", stall, 1);
    // R7 store rt-only match does not stall, rs match does
    set_lu(1, 6'h2B, 5'd2, 5'd8); check_all("R7");
    check(!stall && pc_we, "R7 store data", stall, 0);
    set_lu(1, 6'h2B, 5'd8, 5'd2); check_all("R7");
    check(stall && bubble, "R7 store addr", stall, 1);
    // R8 branch
    set_lu(1, 6'h04, 5'd8, 5'd1); check_all("R8");
    check(stall, "R8 branch rs", stall, 1);
    // R9 load in ID / no memread
    set_lu(1, 6'h23, 5'd8, 5'd8); check_all("R9");
    check(!stall, "R9 load opc", stall, 0);
    set_lu(0, 6'h00, 5'd8, 5'd8); check_all("R9");
    check(!stall, "R9 no memread", stall, 0);
    // R10 hold outputs during stall
    set_lu(1, 6'h00, 5'd8, 5'd0); check_all("R10");
    check(!pc_we && !ifid_we && bubble, "R10 hold", {pc_we, ifid_we, bubble}, 3'b001);

    // random with a narrow register pool
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h1234);
    end
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] opcs [5];
      opcs = '{6'h00, 6'h04, 6'h2B, 6'h23, 6'h08};
      set_fwd(AW'($urandom_range(3)), 1'($urandom), AW'($urandom_range(3)), 1'($urandom),
              AW'($urandom_range(3)), AW'($urandom_range(3)));
      set_lu(1'($urandom), opcs[$urandom_range(4)], AW'($urandom_range(3)), AW'($urandom_range(3)));
      check_all("random R1 R2 R3 R4 R5 R6 R7 R8 R9");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule